// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the raster timing for a TFT panel that takes parallel RGB pixels together with frame sync, line sync, a dot clock and a data-enable strobe. It runs from one clock, and an inverted copy of that clock goes to the panel as the dot clock. Two free-running counters walk each line through sync, back porch, active pixels and front porch. They walk each frame through the same four phases, counted in lines. Line timing never pauses, so line sync pulses keep coming while frame sync is low and during the vertical porches.

One cycle before each active pixel, the block raises a pixel request and gives the pixel's column and row to an upstream source. A registered source then returns that pixel's colour in the next cycle, which is the cycle in which data-enable is high. The block passes the colour through to the panel bus during active video and drives the bus to zero at every other time. All sync widths, porch lengths and active sizes are parameters. The defaults describe a 240 x 320 portrait panel.

Top module: `rgb_panel_timing`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next output state is `hSyncN`=1, `vSyncN`=1, `dataEn`=0, `pixReq`=0 and `rgbOut`=0.
- R2: Reset is synchronous and restarts the frame at the beginning of the frame sync pulse. After the first rising edge at which `rst` is low, the outputs still show the idle state. After the second such edge, `vSyncN` and `hSyncN` are both 0. The first pixel request after a restart carries column 0 and row 0.
- R3: `hSyncN` is low for H_SYNC cycles of every line, and its falling edges are H_SYNC+H_BP+H_ACT+H_FP cycles apart.
- R4: On an active line, `dataEn` rises H_SYNC+H_BP cycles after the falling edge of `hSyncN` and stays high for exactly H_ACT consecutive cycles. `dataEn` is never high while either sync output is low.
- R5: `vSyncN` falls in the same cycle as `hSyncN` and stays low for V_SYNC whole lines. Line sync keeps pulsing during that time.
- R6: The vertical back porch counts the lines from the line on which `vSyncN` returns high to the first line with `dataEn`. It is V_BP lines.
- R7: Each frame has V_ACT lines with `dataEn`. The vertical front porch is V_FP lines, counted from the last such line to the next falling edge of `vSyncN`. A frame lasts V_SYNC+V_BP+V_ACT+V_FP lines.
- R8: `pixReq` is high in exactly the cycles that come directly before a `dataEn`-high cycle. With each request, `pixX` gives the column (0 to H_ACT-1, counted from the first pixel of the line) and `pixY` gives the row (0 to V_ACT-1, counted from the first active line).
- R9: `rgbOut` equals `pixData` while `dataEn` is 1 and is all zeros while `dataEn` is 0.
- R10: `dotClkOut` is the inverse of `clk`. Outputs launched at a rising edge of `clk` are therefore stable at the next rising edge of `dotClkOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pixData | input | COLOR_W | Colour from the pixel source, one cycle after its request |
| dotClkOut | output | 1 | Dot clock to the panel, inverted `clk` |
| hSyncN | output | 1 | Line sync, active low |
| vSyncN | output | 1 | Frame sync, active low |
| dataEn | output | 1 | High while a valid pixel is on `rgbOut` |
| rgbOut | output | COLOR_W | Pixel bus to the panel, zero outside active video |
| pixReq | output | 1 | Pixel request, one cycle ahead of `dataEn` |
| pixX | output | X_W | Column of the requested pixel |
| pixY | output | Y_W | Row of the requested pixel |

## Verification
The bench instance uses small, unequal porch and sync values, so that an exchanged parameter or an off-by-one in any phase shifts a measured width. The pixel source returns a colour unique to each column and row when it is asked, and a fixed nonzero filler value otherwise. A colour check on every active cycle therefore separates correct alignment of the request from alignment one cycle early or late, and from a failure to blank. Several frames are measured after power-on reset. A reset is then applied in the middle of a frame, which shows whether the counters restart at the start of frame sync or simply resume.

// File: rtl/rgbtg_pkg.sv
package rgbtg_pkg;
  // Strobes from the counter control to the output datapath, active high.
  typedef struct packed {
    logic hSync;
    logic vSync;
    logic active;
  } tgStrobes_t;
endpackage

// File: rtl/rgbtg_ctrl.sv
module rgbtg_ctrl
  import rgbtg_pkg::*;
#(
  parameter int H_SYNC = 10,
  parameter int H_BP   = 20,
  parameter int H_ACT  = 240,
  parameter int H_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 2,
  parameter int V_ACT  = 320,
  parameter int V_FP   = 4,
  parameter int X_W    = $clog2(H_ACT),
  parameter int Y_W    = $clog2(V_ACT)
) (
  input  logic           clk,
  input  logic           rst,
  output tgStrobes_t     strobes,
  output logic           pixReq,
  output logic [X_W-1:0] pixX,
  output logic [Y_W-1:0] pixY
);
  localparam int H_TOT = H_SYNC + H_BP + H_ACT + H_FP;
  localparam int V_TOT = V_SYNC + V_BP + V_ACT + V_FP;
  localparam int HC_W  = $clog2(H_TOT);
  localparam int VC_W  = $clog2(V_TOT);
  localparam logic [HC_W-1:0] H_LAST = HC_W'(H_TOT - 1);
  localparam logic [HC_W-1:0] H_SE   = HC_W'(H_SYNC);
  localparam logic [HC_W-1:0] H_AS   = HC_W'(H_SYNC + H_BP);
  localparam logic [HC_W-1:0] H_AE   = HC_W'(H_SYNC + H_BP + H_ACT);
  localparam logic [VC_W-1:0] V_LAST = VC_W'(V_TOT - 1);
  localparam logic [VC_W-1:0] V_SE   = VC_W'(V_SYNC);
  localparam logic [VC_W-1:0] V_AS   = VC_W'(V_SYNC + V_BP);
  localparam logic [VC_W-1:0] V_AE   = VC_W'(V_SYNC + V_BP + V_ACT);
  localparam logic [X_W-1:0]  X_MAX  = X_W'(H_ACT - 1);
  localparam logic [Y_W-1:0]  Y_MAX  = Y_W'(V_ACT - 1);

  logic [HC_W-1:0] hCnt;
  logic [VC_W-1:0] vCnt;
  logic hSyncOn, vSyncOn, hActOn, vActOn, lineAct;

  // Counter zero is the first cycle of the frame sync pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    hSyncOn = (hCnt < H_SE);
    vSyncOn = (vCnt < V_SE);
    hActOn  = (hCnt >= H_AS) && (hCnt < H_AE);
    vActOn  = (vCnt >= V_AS) && (vCnt < V_AE);
    lineAct = hActOn && vActOn;
  end

  // First pipeline stage: request and coordinates lead the panel outputs by one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      strobes <= '0;
      pixX    <= '0;
      pixY    <= '0;
    end else begin
      strobes <= '{hSync: hSyncOn, vSync: vSyncOn, active: lineAct};
      pixX    <= lineAct ? X_W'(hCnt - H_AS) : '0;
      pixY    <= lineAct ? Y_W'(vCnt - V_AS) : '0;
    end
  end

  assign pixReq = strobes.active;

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst) hCnt <= H_LAST);

  // R5
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hCnt != H_LAST) |=> $stable(vCnt));

  // R8
  coord_range_chk: assert property (@(posedge clk) disable iff (rst)
    pixReq |-> (pixX <= X_MAX) && (pixY <= Y_MAX));
endmodule

// File: rtl/rgbtg_dp.sv
module rgbtg_dp
  import rgbtg_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  tgStrobes_t         strobesIn,
  input  logic [COLOR_W-1:0] pixData,
  output logic               hSyncN,
  output logic               vSyncN,
  output logic               dataEn,
  output logic [COLOR_W-1:0] rgbOut
);
  // Second pipeline stage: panel-facing sync and enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      hSyncN <= 1'b1;
      vSyncN <= 1'b1;
      dataEn <= 1'b0;
    end else begin
      hSyncN <= ~strobesIn.hSync;
      vSyncN <= ~strobesIn.vSync;
      dataEn <= strobesIn.active;
    end
  end

  assign rgbOut = dataEn ? pixData : '0;

  // R4
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
    dataEn |-> (hSyncN && vSyncN));

  // R5
  vs_with_hs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vSyncN) |-> !hSyncN);
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
  import rgbtg_pkg::*;
#(
  parameter int H_SYNC  = 10,
  parameter int H_BP    = 20,
  parameter int H_ACT   = 240,
  parameter int H_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 2,
  parameter int V_ACT   = 320,
  parameter int V_FP    = 4,
  parameter int COLOR_W = 24,
  parameter int X_W     = $clog2(H_ACT),
  parameter int Y_W     = $clog2(V_ACT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COLOR_W-1:0] pixData,
  output logic               dotClkOut,
  output logic               hSyncN,
  output logic               vSyncN,
  output logic               dataEn,
  output logic [COLOR_W-1:0] rgbOut,
  output logic               pixReq,
  output logic [X_W-1:0]     pixX,
  output logic [Y_W-1:0]     pixY
);
  tgStrobes_t strobes;

  // R10: panel samples on the inverted clock, mid-way through each output cycle.
  assign dotClkOut = ~clk;

  rgbtg_ctrl #(
    .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT), .H_FP(H_FP),
    .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACT(V_ACT), .V_FP(V_FP),
    .X_W(X_W), .Y_W(Y_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .strobes(strobes),
    .pixReq(pixReq), .pixX(pixX), .pixY(pixY)
  );

  rgbtg_dp #(.COLOR_W(COLOR_W)) i_dp (
    .clk(clk), .rst(rst), .strobesIn(strobes), .pixData(pixData),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .dataEn(dataEn), .rgbOut(rgbOut)
  );
endmodule

// File: tb/test_rgb_panel_timing.sv
module test_rgb_panel_timing;
  localparam int HS = 4, HBP = 6, HACT = 16, HFP = 3;
  localparam int VS = 2, VBP = 3, VACT = 8, VFP = 2;
  localparam int HTOT = HS + HBP + HACT + HFP;
  localparam int VTOT = VS + VBP + VACT + VFP;
  localparam int CW = 24;
  localparam int XW = $clog2(HACT);
  localparam int YW = $clog2(VACT);
  localparam int NV = 13;
  localparam logic [CW-1:0] FILLER = 24'hA5A5A5;

  // Measured quantity index -> expected value, with the requirement it checks.
  localparam int EXPV [NV] = '{HS, HTOT, HS + HBP, HACT, VS, VBP, VACT, VFP, VTOT, 0, 0, 0, 0};
  localparam string TAG [NV] = '{"R3", "R3", "R4", "R4", "R5", "R6", "R7", "R7", "R7",
                                 "R8", "R9", "R8", "R4"};
  localparam string WHAT [NV] = '{"hsync width", "line period", "DE offset", "DE per line",
                                  "vsync lines", "back porch", "DE lines", "front porch",
                                  "frame lines", "req/DE misalign", "rgb mismatch",
                                  "coord mismatch", "bad DE lines"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] pixData = FILLER;
  logic dotClkOut, hSyncN, vSyncN, dataEn, pixReq;
  logic [CW-1:0] rgbOut;
  logic [XW-1:0] pixX;
  logic [YW-1:0] pixY;

  int checks = 0, fails = 0;
  int meas [NV];
  bit mon = 1'b0;
  int frame = 0;

  always #10 clk = ~clk;

  rgb_panel_timing #(
    .H_SYNC(HS), .H_BP(HBP), .H_ACT(HACT), .H_FP(HFP),
    .V_SYNC(VS), .V_BP(VBP), .V_ACT(VACT), .V_FP(VFP), .COLOR_W(CW)
  ) i_rgb_panel_timing (
    .clk(clk), .rst(rst), .pixData(pixData), .dotClkOut(dotClkOut),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .dataEn(dataEn), .rgbOut(rgbOut),
    .pixReq(pixReq), .pixX(pixX), .pixY(pixY)
  );

  function automatic logic [CW-1:0] pat(int x, int y);
    return {8'h5A, 8'(x), 8'(y)};
  endfunction

  // Registered pixel source: answers a request in the next cycle, filler otherwise.
  always_ff @(posedge clk) pixData <= pixReq ? pat(int'(pixX), int'(pixY)) : FILLER;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor state
  int cnt = 0, lastFall = 0, lineIdx = 0, hLow = 0, deCnt = 0, deY = 0;
  int deLinesCur = 0, lastDe = 0, vsRise = 0, reqInLine = 0, reqLines = 0, reqY = 0;
  logic prevH = 1'b1, prevV = 1'b1, prevDe = 1'b0, prevReq = 1'b0;

  always @(negedge clk) begin
    if (mon) begin
      automatic bit hFall  = prevH && !hSyncN;
      automatic bit hRise  = !prevH && hSyncN;
      automatic bit vFall  = prevV && !vSyncN;
      automatic bit vRise  = !prevV && vSyncN;
      automatic bit deRise = !prevDe && dataEn;
      automatic bit deFall = prevDe && !dataEn;
      cnt++;
      if (vFall) begin
        if (frame == 1) begin
          meas[8] = lineIdx + 1;
          meas[7] = lineIdx - lastDe;
          meas[6] = deLinesCur;
        end
        frame++;
        deLinesCur = 0;
        reqLines = 0;
      end
      if (hFall) begin
        if (frame == 1 && !vFall) meas[1] = cnt - lastFall;
        lastFall = cnt;
        lineIdx = vFall ? 0 : lineIdx + 1;
        hLow = 0;
        deCnt = 0;
        reqInLine = 0;
      end
      if (!hSyncN) hLow++;
      if (hRise && frame == 1) meas[0] = hLow;
      if (vRise && frame == 1) begin
        meas[4] = lineIdx;
        vsRise = lineIdx;
      end
      if (deRise && frame >= 1) begin
        if (frame == 1) begin
          meas[2] = cnt - lastFall;
          if (deLinesCur == 0) meas[5] = lineIdx - vsRise;
          lastDe = lineIdx;
        end
        deY = deLinesCur;
        deLinesCur++;
      end
      // R9: colour aligned during DE, zero outside it
      if (dataEn) begin
        if (frame >= 1 && rgbOut != pat(deCnt, deY)) meas[10]++;
        deCnt++;
      end else if (rgbOut != '0) meas[10]++;
      if (deFall && frame == 1) begin
        meas[3] = deCnt;
        if (deCnt != HACT) meas[12]++;
      end
      // R8: request leads DE by one cycle and carries the coordinates
      if (frame >= 1 && prevReq != dataEn) meas[9]++;
      if (pixReq && frame >= 1) begin
        if (reqInLine == 0) begin
          reqY = reqLines;
          reqLines++;
        end
        if (int'(pixX) != reqInLine || int'(pixY) != reqY) meas[11]++;
        reqInLine++;
      end
      prevH = hSyncN;
      prevV = vSyncN;
      prevDe = dataEn;
      prevReq = pixReq;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NV; i++) meas[i] = 0;
    // R1: idle state under reset
    repeat (3) @(negedge clk);
    chk("R1", "hSyncN in reset", int'(hSyncN), 1);
    chk("R1", "vSyncN in reset", int'(vSyncN), 1);
    chk("R1", "dataEn in reset", int'(dataEn), 0);
    chk("R1", "pixReq in reset", int'(pixReq), 0);
    chk("R1", "rgbOut in reset", int'(rgbOut != '0), 0);
    rst = 1'b0;
    mon = 1'b1;
    wait (frame >= 3);
    @(negedge clk);
    for (int i = 0; i < NV; i++) chk(TAG[i], WHAT[i], meas[i], EXPV[i]);

    // R10: dot clock is the inverted clock
    @(negedge clk);
    chk("R10", "dotClkOut while clk low", int'(dotClkOut), 1);
    @(posedge clk);
    #1;
    chk("R10", "dotClkOut while clk high", int'(dotClkOut), 0);

    // R2: mid-frame reset restarts at the start of frame sync
    mon = 1'b0;
    repeat (HTOT * 6 + 5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "vSyncN in mid-frame reset", int'(vSyncN), 1);
    chk("R1", "dataEn in mid-frame reset", int'(dataEn), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "vSyncN one edge after release", int'(vSyncN), 1);
    chk("R2", "hSyncN one edge after release", int'(hSyncN), 1);
    @(negedge clk);
    chk("R2", "vSyncN two edges after release", int'(vSyncN), 0);
    chk("R2", "hSyncN two edges after release", int'(hSyncN), 0);
    wait (pixReq);
    @(negedge clk);
    chk("R2", "first pixX after restart", int'(pixX), 0);
    chk("R2", "first pixY after restart", int'(pixY), 0);
    finishRun();
  end
endmodule